// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block takes a CPU address and finds which of a set of programmable address windows it falls into. Each window is a naturally aligned region of the address space, sized in 64 KiB steps. The block reports the target ID and attribute byte that belong to the matching window, together with the address to send downstream. A window is described by a control word and a base word. The control word holds an enable bit, a contiguous size mask, a target ID and an attribute byte. The lowest-numbered windows also carry a remap pair, so they can move the address to another place in a 64-bit downstream space. The other windows pass the address through unchanged.

Windows may overlap. A typical case is two windows that both cover the boot device while software moves one of them. When windows overlap, the lowest-numbered enabled window wins. Each decode request gives a registered result one cycle later. Configuration goes through a small write/read port. A write changes decoding from the next clock edge onward, and a read returns the stored word one cycle after the address is presented.

Top module: `cpu_win_decoder`

## Requirements
- R1: After reset, every configuration word reads 0, all windows are disabled, and every decode output is 0.
- R2: The configuration address is {window index, selector}, with the selector in the two low bits: 0 is control, 1 is base, 2 is remap-low and 3 is remap-high. Control layout: bit 0 is enable, bits 7:4 are the target ID, bits 15:8 are the attribute, bits 31:16 are the size mask. Any stored word reads back exactly as written, with cfg_rdata valid one cycle after cfg_addr is presented.
- R3: For windows numbered 2 and above, writes to selectors 2 and 3 are ignored and those selectors read 0.
- R4: A window matches only when it is enabled and (addr[31:16] & ~size) equals (base[31:16] & ~size). Base bits 15:0 play no part in matching. A disabled window never matches.
- R5: A size mask of 0x0000 gives a 64 KiB window. A size mask of 0xFFFF matches every address.
- R6: When several windows match, dec_win reports the lowest-numbered one.
- R7: On a hit in window 0 or 1, dec_out_addr is {remap_hi, (remap_lo[31:16] & ~size) | (addr[31:16] & size), addr[15:0]}.
- R8: On a hit in window 2 or above, dec_out_addr is {32'h0, addr}.
- R9: A valid request that matches no window gives dec_miss=1 and dec_hit=0, and sets dec_win, dec_target, dec_attr and dec_out_addr to 0.
- R10: Results appear one cycle after dec_valid is sampled. With dec_valid low, dec_hit and dec_miss are 0 in the next cycle. A decode sampled on the same edge as a configuration write uses the configuration from before that write.
- R11: On a hit, dec_target and dec_attr equal the target ID and attribute fields of the winning window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | WIN_W+2 | {window index, register selector} |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cfg_rdata | output | ADDR_W | Registered read data for cfg_addr |
| dec_valid | input | 1 | Decode request valid |
| dec_addr | input | ADDR_W | CPU address to decode |
| dec_hit | output | 1 | A window matched |
| dec_miss | output | 1 | A valid request matched no window |
| dec_win | output | WIN_W | Index of the winning window |
| dec_target | output | TGT_W | Target ID of the winning window |
| dec_attr | output | ATTR_W | Attribute of the winning window |
| dec_out_addr | output | 2*ADDR_W | Translated downstream address |

## Verification
A configuration write and a decode can land on the same clock edge. The write may disable or re-enable the very window that the request would hit. The bench provokes this by raising cfg_wr to a window's control word in the same cycle as dec_valid, with an address inside that window, first when turning the window off and then when turning it back on. It judges the result by requiring the old configuration to decide that decode. In the first case the old window still hits; in the second the request still misses. The next request to the same address must then see the new configuration.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

   // register selector carried in the low bits of the configuration address
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_BASE = 2'd1,
      SEL_RLO  = 2'd2,
      SEL_RHI  = 2'd3
   } cwd_sel_e;

   // control word field positions
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_TGT_LSB  = 4;
   localparam int CTRL_ATTR_LSB = 8;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile
   import cwd_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int NUM_REMAP = 2,
   parameter int ADDR_W    = 32,
   parameter int GRAN_W    = 16,
   parameter int TGT_W     = 4,
   parameter int ATTR_W    = 8,
   parameter int WIN_W     = 3,
   localparam int SIZE_W   = ADDR_W - GRAN_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_wr,
   input  logic [WIN_W-1:0]                   cfg_win,
   input  logic [1:0]                         cfg_sel,
   input  logic [ADDR_W-1:0]                  cfg_wdata,
   output logic [ADDR_W-1:0]                  cfg_rdata,
   output logic [NUM_WIN-1:0]                 win_en,
   output logic [NUM_WIN-1:0][SIZE_W-1:0]     win_size,
   output logic [NUM_WIN-1:0][SIZE_W-1:0]     win_base,
   output logic [NUM_WIN-1:0][TGT_W-1:0]      win_tgt,
   output logic [NUM_WIN-1:0][ATTR_W-1:0]     win_attr,
   output logic [NUM_REMAP-1:0][SIZE_W-1:0]   rmp_lo,
   output logic [NUM_REMAP-1:0][ADDR_W-1:0]   rmp_hi
);

   localparam logic [WIN_W:0] WIN_LIMIT = (WIN_W+1)'(NUM_WIN);

   logic [NUM_WIN-1:0][ADDR_W-1:0] rd_vec;
   logic                           win_in_range;

   assign win_in_range = {1'b0, cfg_win} < WIN_LIMIT;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic              wsel;
      logic [ADDR_W-1:0] ctrl_r;
      logic [ADDR_W-1:0] base_r;

      assign wsel = cfg_wr && (cfg_win == WIN_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_r <= '0;
            base_r <= '0;
         end else if (wsel) begin
            if (cfg_sel == SEL_CTRL) ctrl_r <= cfg_wdata;
            if (cfg_sel == SEL_BASE) base_r <= cfg_wdata;
         end
      end

      assign win_en[w]   = ctrl_r[CTRL_EN_BIT];
      assign win_tgt[w]  = ctrl_r[CTRL_TGT_LSB +: TGT_W];
      assign win_attr[w] = ctrl_r[CTRL_ATTR_LSB +: ATTR_W];
      assign win_size[w] = ctrl_r[ADDR_W-1:GRAN_W];
      assign win_base[w] = base_r[ADDR_W-1:GRAN_W];

      if (w < NUM_REMAP) begin : g_remap
         logic [ADDR_W-1:0] rlo_r;
         logic [ADDR_W-1:0] rhi_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rlo_r <= '0;
               rhi_r <= '0;
            end else if (wsel) begin
               if (cfg_sel == SEL_RLO) rlo_r <= cfg_wdata;
               if (cfg_sel == SEL_RHI) rhi_r <= cfg_wdata;
            end
         end

         assign rmp_lo[w] = rlo_r[ADDR_W-1:GRAN_W];
         assign rmp_hi[w] = rhi_r;
         assign rd_vec[w] = (cfg_sel == SEL_CTRL) ? ctrl_r :
                            (cfg_sel == SEL_BASE) ? base_r :
                            (cfg_sel == SEL_RLO)  ? rlo_r  : rhi_r;
      end else begin : g_plain
         assign rd_vec[w] = (cfg_sel == SEL_CTRL) ? ctrl_r :
                            (cfg_sel == SEL_BASE) ? base_r : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cfg_rdata <= '0;
      else if (win_in_range)  cfg_rdata <= rd_vec[cfg_win];
      else                    cfg_rdata <= '0;
   end

endmodule

// File: rtl/cwd_win_match.sv
module cwd_win_match #(
   parameter int SIZE_W = 16
) (
   input  logic              en,
   input  logic [SIZE_W-1:0] size,
   input  logic [SIZE_W-1:0] base_hi,
   input  logic [SIZE_W-1:0] addr_hi,
   output logic              match
);

   // the size mask marks the bits that are offset within the window
   assign match = en && (((addr_hi ^ base_hi) & ~size) == '0);

endmodule

// File: rtl/cwd_xlat.sv
module cwd_xlat #(
   parameter int ADDR_W  = 32,
   parameter int GRAN_W  = 16,
   localparam int SIZE_W = ADDR_W - GRAN_W
) (
   input  logic [SIZE_W-1:0]   size,
   input  logic [SIZE_W-1:0]   rlo_hi,
   input  logic [ADDR_W-1:0]   rhi,
   input  logic [ADDR_W-1:0]   addr,
   output logic [2*ADDR_W-1:0] xaddr
);

   logic [SIZE_W-1:0] new_hi;

   assign new_hi = (rlo_hi & ~size) | (addr[ADDR_W-1:GRAN_W] & size);
   assign xaddr  = {rhi, new_hi, addr[GRAN_W-1:0]};

endmodule

// File: rtl/cwd_prio_pick.sv
module cwd_prio_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);

   always_comb begin
      gnt = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) gnt = N'(1) << i;
      end
   end

   assign any = |req;

endmodule

// File: rtl/cpu_win_decoder.sv
module cpu_win_decoder
   import cwd_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int NUM_REMAP = 2,
   parameter int ADDR_W    = 32,
   parameter int GRAN_W    = 16,
   parameter int TGT_W     = 4,
   parameter int ATTR_W    = 8,
   localparam int WIN_W    = idx_width(NUM_WIN)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic [WIN_W+1:0]      cfg_addr,
   input  logic [ADDR_W-1:0]     cfg_wdata,
   output logic [ADDR_W-1:0]     cfg_rdata,
   input  logic                  dec_valid,
   input  logic [ADDR_W-1:0]     dec_addr,
   output logic                  dec_hit,
   output logic                  dec_miss,
   output logic [WIN_W-1:0]      dec_win,
   output logic [TGT_W-1:0]      dec_target,
   output logic [ATTR_W-1:0]     dec_attr,
   output logic [2*ADDR_W-1:0]   dec_out_addr
);

   localparam int SIZE_W = ADDR_W - GRAN_W;
   localparam int OUT_W  = 2 * ADDR_W;

   // elaboration-time parameter checks
   if (NUM_REMAP < 1 || NUM_REMAP > NUM_WIN) begin : g_err_remap
      $error("NUM_REMAP must be between 1 and NUM_WIN");
   end
   if (GRAN_W < CTRL_ATTR_LSB + ATTR_W || SIZE_W < 1) begin : g_err_gran
      $error("GRAN_W too small for control fields or too large for ADDR_W");
   end
   if (TGT_W > CTRL_ATTR_LSB - CTRL_TGT_LSB || TGT_W < 1) begin : g_err_tgt
      $error("TGT_W does not fit its control field");
   end

   logic [NUM_WIN-1:0]               win_en;
   logic [NUM_WIN-1:0][SIZE_W-1:0]   win_size;
   logic [NUM_WIN-1:0][SIZE_W-1:0]   win_base;
   logic [NUM_WIN-1:0][TGT_W-1:0]    win_tgt;
   logic [NUM_WIN-1:0][ATTR_W-1:0]   win_attr;
   logic [NUM_REMAP-1:0][SIZE_W-1:0] rmp_lo;
   logic [NUM_REMAP-1:0][ADDR_W-1:0] rmp_hi;

   cwd_regfile #(
      .NUM_WIN  (NUM_WIN),
      .NUM_REMAP(NUM_REMAP),
      .ADDR_W   (ADDR_W),
      .GRAN_W   (GRAN_W),
      .TGT_W    (TGT_W),
      .ATTR_W   (ATTR_W),
      .WIN_W    (WIN_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_win  (cfg_addr[WIN_W+1:2]),
      .cfg_sel  (cfg_addr[1:0]),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .win_en   (win_en),
      .win_size (win_size),
      .win_base (win_base),
      .win_tgt  (win_tgt),
      .win_attr (win_attr),
      .rmp_lo   (rmp_lo),
      .rmp_hi   (rmp_hi)
   );

   logic [NUM_WIN-1:0]            match_v;
   logic [NUM_WIN-1:0]            gnt_v;
   logic                          any_match;
   logic [NUM_WIN-1:0][OUT_W-1:0] xlat_v;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_dec
      cwd_win_match #(.SIZE_W(SIZE_W)) u_match (
         .en     (win_en[w]),
         .size   (win_size[w]),
         .base_hi(win_base[w]),
         .addr_hi(dec_addr[ADDR_W-1:GRAN_W]),
         .match  (match_v[w])
      );

      if (w < NUM_REMAP) begin : g_xlat
         cwd_xlat #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_xlat (
            .size  (win_size[w]),
            .rlo_hi(rmp_lo[w]),
            .rhi   (rmp_hi[w]),
            .addr  (dec_addr),
            .xaddr (xlat_v[w])
         );
      end else begin : g_pass
         assign xlat_v[w] = {{ADDR_W{1'b0}}, dec_addr};
      end
   end

   cwd_prio_pick #(.N(NUM_WIN)) u_pick (
      .req(match_v),
      .gnt(gnt_v),
      .any(any_match)
   );

   logic [WIN_W-1:0]  sel_win;
   logic [TGT_W-1:0]  sel_tgt;
   logic [ATTR_W-1:0] sel_attr;
   logic [OUT_W-1:0]  sel_out;

   // one-hot AND-OR selection: no match leaves every field at zero
   always_comb begin
      sel_win  = '0;
      sel_tgt  = '0;
      sel_attr = '0;
      sel_out  = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (gnt_v[i]) begin
            sel_win  = sel_win  | WIN_W'(i);
            sel_tgt  = sel_tgt  | win_tgt[i];
            sel_attr = sel_attr | win_attr[i];
            sel_out  = sel_out  | xlat_v[i];
         end
      end
   end

   logic take;
   assign take = dec_valid && any_match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_hit      <= 1'b0;
         dec_miss     <= 1'b0;
         dec_win      <= '0;
         dec_target   <= '0;
         dec_attr     <= '0;
         dec_out_addr <= '0;
      end else begin
         dec_hit      <= take;
         dec_miss     <= dec_valid && !any_match;
         dec_win      <= take ? sel_win  : '0;
         dec_target   <= take ? sel_tgt  : '0;
         dec_attr     <= take ? sel_attr : '0;
         dec_out_addr <= take ? sel_out  : '0;
      end
   end

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
   parameter int NUM_WIN   = 8,
   parameter int NUM_REMAP = 2,
   parameter int ADDR_W    = 32,
   parameter int GRAN_W    = 16,
   parameter int TGT_W     = 4,
   parameter int ATTR_W    = 8,
   localparam int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                dec_valid,
   input logic [ADDR_W-1:0]   dec_addr,
   input logic                dec_hit,
   input logic                dec_miss,
   input logic [WIN_W-1:0]    dec_win,
   input logic [TGT_W-1:0]    dec_target,
   input logic [ATTR_W-1:0]   dec_attr,
   input logic [2*ADDR_W-1:0] dec_out_addr
);

   assert_hit_miss_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_hit && dec_miss));

   assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_miss |-> (dec_win == '0 && dec_target == '0 && dec_attr == '0 &&
                    dec_out_addr == '0));

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |=> (!dec_hit && !dec_miss));

   assert_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> (dec_hit || dec_miss));

   assert_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> (!dec_hit ||
                     dec_out_addr[GRAN_W-1:0] == $past(dec_addr[GRAN_W-1:0])));

   assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> (!dec_hit || int'(dec_win) < NUM_REMAP ||
                     dec_out_addr == {{ADDR_W{1'b0}}, $past(dec_addr)}));

endmodule

bind cpu_win_decoder cwd_checker #(
   .NUM_WIN  (NUM_WIN),
   .NUM_REMAP(NUM_REMAP),
   .ADDR_W   (ADDR_W),
   .GRAN_W   (GRAN_W),
   .TGT_W    (TGT_W),
   .ATTR_W   (ATTR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dec_valid   (dec_valid),
   .dec_addr    (dec_addr),
   .dec_hit     (dec_hit),
   .dec_miss    (dec_miss),
   .dec_win     (dec_win),
   .dec_target  (dec_target),
   .dec_attr    (dec_attr),
   .dec_out_addr(dec_out_addr)
);

// File: tb/cpu_win_decoder_bench.sv
`timescale 1ns/1ps
module cpu_win_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr;
   logic [4:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic        dec_valid;
   logic [31:0] dec_addr;
   logic        dec_hit;
   logic        dec_miss;
   logic [2:0]  dec_win;
   logic [3:0]  dec_target;
   logic [7:0]  dec_attr;
   logic [63:0] dec_out_addr;

   always #2 clk = ~clk;

   cpu_win_decoder u_cpu_win_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dec_valid(dec_valid),
      .dec_addr(dec_addr), .dec_hit(dec_hit), .dec_miss(dec_miss),
      .dec_win(dec_win), .dec_target(dec_target), .dec_attr(dec_attr),
      .dec_out_addr(dec_out_addr)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [31:0] sh_ctrl [8];
   logic [31:0] sh_base [8];
   logic [31:0] sh_rlo  [2];
   logic [31:0] sh_rhi  [2];
   logic [31:0] pa;

   function automatic logic [31:0] mk_ctrl(bit en, logic [15:0] sz, logic [3:0] t,
                                           logic [7:0] a);
      return {sz, a, t, 3'b000, en};
   endfunction

   // expected {hit, miss, win, target, attr, out_addr} from the requirements
   function automatic logic [80:0] model(bit v, logic [31:0] a);
      logic [80:0] e;
      e = '0;
      if (v) begin
         e[79] = 1'b1;
         for (int w = 7; w >= 0; w--) begin
            logic [15:0] sz;
            logic [63:0] o;
            sz = sh_ctrl[w][31:16];
            if (sh_ctrl[w][0] && ((a[31:16] & ~sz) == (sh_base[w][31:16] & ~sz))) begin
               if (w < 2)
                  o = {sh_rhi[w], (sh_rlo[w][31:16] & ~sz) | (a[31:16] & sz), a[15:0]};
               else
                  o = {32'h0, a};
               e = {1'b1, 1'b0, 3'(w), sh_ctrl[w][7:4], sh_ctrl[w][15:8], o};
            end
         end
      end
      return e;
   endfunction

   task automatic chk(string tag, logic [80:0] act, logic [80:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic dec_check(string tag, bit v, logic [31:0] a);
      chk(tag, {dec_hit, dec_miss, dec_win, dec_target, dec_attr, dec_out_addr}, model(v, a));
   endtask

   task automatic shadow(int w, int sel, logic [31:0] d);
      case (sel)
         0: sh_ctrl[w] = d;
         1: sh_base[w] = d;
         2: if (w < 2) sh_rlo[w] = d;
         default: if (w < 2) sh_rhi[w] = d;
      endcase
   endtask

   task automatic wr(int w, int sel, logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = {3'(w), 2'(sel)}; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      shadow(w, sel, d);
   endtask

   task automatic rd(string tag, int w, int sel, logic [31:0] exp);
      @(negedge clk);
      cfg_addr = {3'(w), 2'(sel)};
      @(negedge clk);
      chk(tag, {49'h0, cfg_rdata}, {49'h0, exp});
   endtask

   task automatic one(string tag, logic [31:0] a);
      @(negedge clk);
      dec_valid = 1'b1; dec_addr = a;
      @(negedge clk);
      dec_check(tag, 1'b1, a);
      dec_valid = 1'b0;
   endtask

   // pipelined sweep: one request per cycle, each checked a cycle later
   task automatic sweep(string tag, int step);
      int n;
      n = 65536 / step;
      for (int i = 0; i <= n; i++) begin
         @(negedge clk);
         if (i > 0) dec_check(tag, 1'b1, pa);
         if (i < n) begin
            pa = {16'(i * step), 16'(i * 40503)};
            dec_valid = 1'b1; dec_addr = pa;
         end else begin
            dec_valid = 1'b0;
         end
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL R10: actual run still busy expected finished (watchdog)");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int w = 0; w < 8; w++) begin sh_ctrl[w] = '0; sh_base[w] = '0; end
      for (int w = 0; w < 2; w++) begin sh_rlo[w] = '0; sh_rhi[w] = '0; end
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      dec_valid = 1'b0; dec_addr = '0; pa = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      dec_check("R1", 1'b0, 32'h0);
      rd("R1", 0, 0, 32'h0);
      rd("R1", 1, 3, 32'h0);
      one("R1", 32'h9000_0000);

      // configuration A
      wr(0, 1, 32'h9000_0000); wr(0, 2, 32'h3000_0000); wr(0, 3, 32'h0000_0007);
      wr(0, 0, mk_ctrl(1, 16'h0FFF, 4'h4, 8'h59));
      wr(1, 1, 32'hF000_0000); wr(1, 2, 32'hF000_0000); wr(1, 3, 32'h0);
      wr(1, 0, mk_ctrl(1, 16'h00FF, 4'h4, 8'h51));
      wr(2, 1, 32'h8000_0000); wr(2, 0, mk_ctrl(1, 16'h0FFF, 4'h3, 8'h59));
      wr(3, 1, 32'hF010_0000); wr(3, 0, mk_ctrl(1, 16'h000F, 4'h3, 8'h51));
      wr(4, 1, 32'hFA00_ABCD); wr(4, 0, mk_ctrl(1, 16'h0000, 4'h1, 8'h1E));
      wr(5, 1, 32'hFA80_0000); wr(5, 0, mk_ctrl(0, 16'h001F, 4'h1, 8'h1D));
      wr(6, 1, 32'hFF00_0000); wr(6, 0, mk_ctrl(1, 16'h00FF, 4'h1, 8'h0F));
      wr(7, 1, 32'hFF00_0000); wr(7, 0, mk_ctrl(1, 16'h00FF, 4'h2, 8'h0E));

      // R2: readback of stored words, low base bits kept
      rd("R2", 0, 0, mk_ctrl(1, 16'h0FFF, 4'h4, 8'h59));
      rd("R2", 4, 1, 32'hFA00_ABCD);
      rd("R2", 0, 2, 32'h3000_0000);
      rd("R2", 0, 3, 32'h0000_0007);
      // R3: remap words absent above window 1
      wr(4, 2, 32'hDEAD_BEEF); wr(4, 3, 32'h1234_5678);
      rd("R3", 4, 2, 32'h0);
      rd("R3", 4, 3, 32'h0);

      one("R4", 32'hFA80_0010);     // disabled window 5
      one("R5", 32'hFA00_FFFF);     // 64 KiB window, last byte
      one("R5", 32'hFA01_0000);     // just past it
      one("R6", 32'hF010_0004);     // windows 1 and 3 overlap
      one("R6", 32'hFF12_3456);     // windows 6 and 7 overlap
      one("R7", 32'h9123_4567);     // remapped window 0
      one("R7", 32'hF0AB_CDEF);     // window 1 identity remap
      one("R8", 32'h8555_0001);
      one("R11", 32'hFA00_0100);
      one("R9", 32'h1000_0000);
      @(negedge clk);
      dec_check("R10", 1'b0, 32'h0);
      sweep("R4", 1);

      // R6: drop window 6, overlap now resolves to window 7
      wr(6, 0, 32'h0);
      one("R6", 32'hFF00_0000);

      // R10: write and decode on the same edge
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = {3'd2, 2'd0}; cfg_wdata = 32'h0;
      dec_valid = 1'b1; dec_addr = 32'h8000_1234;
      @(negedge clk);
      cfg_wr = 1'b0; dec_valid = 1'b0;
      dec_check("R10", 1'b1, 32'h8000_1234);   // old config: window 2 hits
      shadow(2, 0, 32'h0);
      one("R10", 32'h8000_1234);               // now a miss
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = {3'd2, 2'd0}; cfg_wdata = mk_ctrl(1, 16'h0FFF, 4'h3, 8'h59);
      dec_valid = 1'b1; dec_addr = 32'h8000_1234;
      @(negedge clk);
      cfg_wr = 1'b0; dec_valid = 1'b0;
      dec_check("R10", 1'b1, 32'h8000_1234);   // old config: still a miss
      shadow(2, 0, mk_ctrl(1, 16'h0FFF, 4'h3, 8'h59));
      one("R10", 32'h8000_1234);               // hit again

      // configuration B: window 7 covers everything
      for (int w = 0; w < 7; w++) wr(w, 0, 32'h0);
      wr(7, 1, 32'h1234_0000);
      wr(7, 0, mk_ctrl(1, 16'hFFFF, 4'h9, 8'hA5));
      sweep("R5", 61);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule